// File: doc/BRIEF.md
# XGMII Transmit Framer with Deficit Idle

This block turns a queue of Ethernet frames, each presented as a byte stream that begins with its preamble and start-of-frame delimiter, into 64-bit words for an XGMII transmit bus. Each word has eight byte lanes and one control bit per lane. The block replaces the first byte of every frame with a Start character. It puts a Terminate character right after the last byte and fills the rest of that word with Idle characters. Between frames it inserts idle characters to hold the inter-frame gap.

A frame may start in lane 0 or in lane 4. A deficit counter records how many idle bytes a gap was shortened by, and later gaps make that shortfall good, so the long-run average gap stays at the nominal twelve bytes. When the deficit feature is turned off, the block falls back to a plain rule: it sends a whole idle word while more than four gap bytes are still owed. A second configuration input makes every frame start in lane 4.

The block fills one lane per clock. It publishes a finished word every eight cycles together with a one-cycle strobe. The input side has valid, last and ready signals. Once a frame has started, its bytes must arrive back to back.

Top module: `xgmii_tx_framer`

## Requirements
- R1: The first input byte of a frame is dropped and its lane carries Start (0xFB, control bit 1). The following input bytes appear unchanged in later lanes, in order, with control bit 0.
- R2: The lane after the last byte of a frame carries Terminate (0xFD, control bit 1). Every later lane in that word carries Idle (0x07, control bit 1).
- R3: With deficit enabled, Terminate in lane k (0..7) leaves a gap count of max(12 − (8 − k), 0). While gap plus deficit exceeds 7, a word boundary emits an all-Idle word and reduces the gap by 8. If the gap goes negative, that negative amount is added to the deficit, the deficit is clamped at 0, and the gap is cleared.
- R4: With deficit enabled, a frame that is ready at a word boundary starts in lane 4 when the gap exceeds 3 − deficit. Lanes 0–3 are then Idle and 4 is taken off the gap. Whichever lane the frame starts in, the deficit becomes max(deficit + gap, 0), the gap becomes 0, and the deficit never leaves 0..3.
- R5: With deficit disabled, an all-Idle word is sent while the gap exceeds 4. A frame then starts in lane 0 unless the start is forced, and the deficit stays 0.
- R6: At a word boundary with no pending gap word and no frame offered, the word is all Idle and both the gap and the deficit counts are cleared.
- R7: While the force input is high at a word boundary where a frame starts, the Start character goes in lane 4.
- R8: During reset the output word is all Idle with all control bits set. A word strobe then pulses for exactly one cycle every eight cycles. The first word is formed from the eight lanes of cycles 0–7 after reset, with lane 0 taken from the earliest cycle.
- R9: Ready is high only in the cycles whose lane carries Start or frame data. The number of bytes accepted during a word equals the number of Start and data lanes in that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dicEnable | input | 1 | Enables deficit idle averaging |
| forceLane4 | input | 1 | Forces every frame to start in lane 4 |
| inData | input | 8 | Frame byte; the first byte of a frame is the preamble |
| inValid | input | 1 | inData is valid |
| inLast | input | 1 | inData is the last byte of its frame |
| inReady | output | 1 | The byte is accepted at this edge |
| xgmiiData | output | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| xgmiiCtrl | output | 8 | Per-lane control bits, lane 0 in bit 0 |
| wordValid | output | 1 | One-cycle strobe for a new word |

## Verification
Frames of random length (8 to 40 bytes) are offered mostly back to back, so Terminate lands in every lane and the deficit moves across its whole range. Occasional multi-word pauses show whether the counters are cleared when no frame is waiting. The run passes through four configuration phases: deficit on, deficit off, forced lane 4 with deficit on, and forced lane 4 with deficit off. Each phase separates a different gap rule and start-lane choice. The bench compares every word and every per-word count of accepted bytes with a lane-queue model, so a wrong start lane, a misplaced Terminate or an off-by-one in the gap all show up as word mismatches.

// File: rtl/xgmii_tx_pkg.sv
package xgmii_tx_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
  localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
  localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_START,
    OP_DATA,
    OP_TERM
  } laneOp_e;

  typedef struct packed {
    laneOp_e op;
    logic    publish;
  } laneStrobe_t;

endpackage

// File: rtl/xgmii_tx_ctrl.sv
module xgmii_tx_ctrl
  import xgmii_tx_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int NOMINAL_GAP = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        dicEnable,
  input  logic        forceLane4,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output laneStrobe_t strobe
);

  localparam int HALF = LANES / 2;
  localparam int LW   = $clog2(LANES);
  localparam int CW   = $clog2(NOMINAL_GAP + LANES + 1) + 2;

  localparam logic signed [CW-1:0] LANES_S = CW'(LANES);
  localparam logic signed [CW-1:0] HALF_S  = CW'(HALF);
  localparam logic signed [CW-1:0] GAP_S   = CW'(NOMINAL_GAP);
  localparam logic signed [CW-1:0] ZERO_S  = '0;
  localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);
  localparam logic [LW-1:0] HALF_LANE = LW'(HALF);

  typedef enum logic [1:0] {PH_GAP, PH_LEAD, PH_DATA, PH_TERM} phase_e;

  function automatic logic signed [CW-1:0] floorZero(input logic signed [CW-1:0] v);
    return (v < ZERO_S) ? ZERO_S : v;
  endfunction

  phase_e phase, phaseNext;
  logic [LW-1:0] laneCnt;
  logic signed [CW-1:0] ifgCnt, ifgNext, dicCnt, dicNext;
  logic signed [CW-1:0] sumGap, afterIdle, laneExt;
  logic decide, idleWord, startHalf;
  laneOp_e opNow;

  assign laneExt   = $signed({{(CW-LW){1'b0}}, laneCnt});
  assign sumGap    = ifgCnt + dicCnt;
  assign afterIdle = ifgCnt - LANES_S;
  assign decide    = (phase == PH_GAP) && (laneCnt == '0);
  assign idleWord  = dicEnable ? (sumGap >= LANES_S) : (ifgCnt > HALF_S);
  assign startHalf = forceLane4 || (dicEnable && (sumGap >= HALF_S));

  always_comb begin
    opNow     = OP_IDLE;
    phaseNext = phase;
    ifgNext   = ifgCnt;
    dicNext   = dicCnt;
    unique case (phase)
      PH_GAP: begin
        if (decide) begin
          if (idleWord) begin
            if (afterIdle < ZERO_S) begin
              ifgNext = ZERO_S;
              if (dicEnable) dicNext = floorZero(dicCnt + afterIdle);
            end else begin
              ifgNext = afterIdle;
            end
          end else if (inValid) begin
            ifgNext = ZERO_S;
            if (startHalf) begin
              phaseNext = PH_LEAD;
              if (dicEnable) dicNext = floorZero(sumGap - HALF_S);
            end else begin
              opNow     = OP_START;
              phaseNext = inLast ? PH_TERM : PH_DATA;
              if (dicEnable) dicNext = floorZero(sumGap);
            end
          end else begin
            ifgNext = ZERO_S;
            dicNext = ZERO_S;
          end
        end
      end
      PH_LEAD: begin
        if (laneCnt == HALF_LANE) begin
          opNow     = OP_START;
          phaseNext = inLast ? PH_TERM : PH_DATA;
        end
      end
      PH_DATA: begin
        opNow = OP_DATA;
        if (inLast) phaseNext = PH_TERM;
      end
      PH_TERM: begin
        opNow     = OP_TERM;
        phaseNext = PH_GAP;
        ifgNext   = floorZero(GAP_S - LANES_S + laneExt);
      end
      default: phaseNext = PH_GAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_GAP;
      laneCnt <= '0;
      ifgCnt  <= ZERO_S;
      dicCnt  <= ZERO_S;
    end else begin
      phase   <= phaseNext;
      laneCnt <= (laneCnt == LAST_LANE) ? '0 : laneCnt + 1'b1;
      ifgCnt  <= ifgNext;
      dicCnt  <= dicNext;
    end
  end

  assign inReady        = (opNow == OP_START) || (opNow == OP_DATA);
  assign strobe.op      = opNow;
  assign strobe.publish = (laneCnt == LAST_LANE);

  // Start may only sit in lane 0 or the middle lane
  assert_start_lane_R4: assert property (@(posedge clk) disable iff (rst)
    (opNow == OP_START) |-> (laneCnt == '0 || laneCnt == HALF_LANE));

  // Deficit stays inside 0 .. HALF-1
  assert_deficit_range_R4: assert property (@(posedge clk) disable iff (rst)
    (dicCnt >= ZERO_S) && (dicCnt < HALF_S));

  // With averaging off, a zero deficit stays zero
  assert_no_deficit_R5: assert property (@(posedge clk) disable iff (rst)
    (!dicEnable && dicCnt == ZERO_S) |=> (dicCnt == ZERO_S));

  // Empty boundary clears both counters
  assert_counters_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (decide && !idleWord && !inValid) |=> (ifgCnt == ZERO_S && dicCnt == ZERO_S));

  // Terminate is always followed by an idle lane
  assert_term_then_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (opNow == OP_TERM) |=> (opNow == OP_IDLE));

endmodule

// File: rtl/xgmii_tx_datapath.sv
module xgmii_tx_datapath
  import xgmii_tx_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  laneStrobe_t             strobe,
  input  logic [BYTE_W-1:0]       inData,
  output logic [LANES*BYTE_W-1:0] outData,
  output logic [LANES-1:0]        outCtrl,
  output logic                    outValid
);

  localparam int DEPTH = LANES - 1;

  logic [BYTE_W:0] laneNow;
  logic [BYTE_W:0] stage [0:DEPTH-1];
  logic [LANES*BYTE_W-1:0] wordData;
  logic [LANES-1:0] wordCtrl;

  always_comb begin
    unique case (strobe.op)
      OP_START: laneNow = {1'b1, CH_START};
      OP_DATA:  laneNow = {1'b0, inData};
      OP_TERM:  laneNow = {1'b1, CH_TERM};
      default:  laneNow = {1'b1, CH_IDLE};
    endcase
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gStage
    if (i == DEPTH - 1) begin : gTail
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= {1'b1, CH_IDLE};
        else     stage[i] <= laneNow;
      end
    end else begin : gMid
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= {1'b1, CH_IDLE};
        else     stage[i] <= stage[i+1];
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : gLane
    if (j == LANES - 1) begin : gNewest
      assign wordData[j*BYTE_W +: BYTE_W] = laneNow[BYTE_W-1:0];
      assign wordCtrl[j]                  = laneNow[BYTE_W];
    end else begin : gHeld
      assign wordData[j*BYTE_W +: BYTE_W] = stage[j][BYTE_W-1:0];
      assign wordCtrl[j]                  = stage[j][BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= {LANES{CH_IDLE}};
      outCtrl  <= '1;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.publish;
      if (strobe.publish) begin
        outData <= wordData;
        outCtrl <= wordCtrl;
      end
    end
  end

  // Word strobe is a single-cycle pulse
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // Output word only changes together with the strobe
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData));

endmodule

// File: rtl/xgmii_tx_framer.sv
module xgmii_tx_framer
  import xgmii_tx_pkg::*;
#(
  parameter int LANES       = 8,
  parameter int NOMINAL_GAP = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dicEnable,
  input  logic                    forceLane4,
  input  logic [7:0]              inData,
  input  logic                    inValid,
  input  logic                    inLast,
  output logic                    inReady,
  output logic [LANES*8-1:0]      xgmiiData,
  output logic [LANES-1:0]        xgmiiCtrl,
  output logic                    wordValid
);

  laneStrobe_t strobe;

  xgmii_tx_ctrl #(.LANES(LANES), .NOMINAL_GAP(NOMINAL_GAP)) ctrl_i (
    .clk(clk), .rst(rst), .dicEnable(dicEnable), .forceLane4(forceLane4),
    .inValid(inValid), .inLast(inLast), .inReady(inReady), .strobe(strobe)
  );

  xgmii_tx_datapath #(.LANES(LANES)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe), .inData(inData),
    .outData(xgmiiData), .outCtrl(xgmiiCtrl), .outValid(wordValid)
  );

endmodule

// File: tb/xgmii_tx_framer_tb.sv
`timescale 1ns/1ps
module xgmii_tx_framer_tb_top;

  localparam int NF  = 64;
  localparam int GAP = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dicEnable = 1'b1, forceLane4 = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic inReady;
  logic [63:0] xgmiiData;
  logic [7:0] xgmiiCtrl;
  logic wordValid;

  always #2 clk = ~clk;

  xgmii_tx_framer dut_i (
    .clk(clk), .rst(rst), .dicEnable(dicEnable), .forceLane4(forceLane4),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .xgmiiData(xgmiiData), .xgmiiCtrl(xgmiiCtrl), .wordValid(wordValid)
  );

  int checks = 0, failures = 0;
  bit reported = 0;

  logic [7:0] fb [0:4095];
  int fs [NF], fl [NF], rel [NF];

  // model state
  logic [8:0] mq [$];
  int mIfg = 0, mDic = 0, nextF = 0;
  logic [63:0] expData;
  logic [7:0] expCtrl;
  int expCons;
  string expTag;

  // driver state
  int curF = 0, idx = 0, hsCnt = 0;
  bit active = 0;

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  task automatic checkEq(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int maxZero(int v);
    return (v < 0) ? 0 : v;
  endfunction

  // configuration phases: averaging on, off, forced+on, forced+off
  function automatic logic [1:0] cfgFor(int w);
    if (w < 110) return 2'b01;
    if (w < 200) return 2'b00;
    if (w < 280) return 2'b11;
    return 2'b10;
  endfunction

  task automatic modelWord(int w);
    int s;
    bit en, frc, lane4;
    logic [8:0] it;
    en = cfgFor(w)[0];
    frc = cfgFor(w)[1];
    expCons = 0;
    s = 0;
    if (mq.size() == 0) begin
      s = 8;
      if (en ? (mIfg + mDic > 7) : (mIfg > 4)) begin
        int t = mIfg - 8;
        expTag = en ? "R3" : "R5";
        if (t < 0) begin
          if (en) mDic = maxZero(mDic + t);
          mIfg = 0;
        end else mIfg = t;
      end else if (nextF < NF && rel[nextF] <= w) begin
        int t;
        lane4 = frc || (en && (mIfg > 3 - mDic));
        expTag = frc ? "R7" : (lane4 ? "R4" : "R1");
        t = lane4 ? mIfg - 4 : mIfg;
        if (en) mDic = maxZero(mDic + t);
        mIfg = 0;
        mq.push_back({1'b1, 8'hFB});
        for (int b = 1; b < fl[nextF]; b++) mq.push_back({1'b0, fb[fs[nextF]+b]});
        mq.push_back({1'b1, 8'hFD});
        nextF++;
        s = lane4 ? 4 : 0;
      end else begin
        expTag = "R6";
        mIfg = 0;
        mDic = 0;
      end
    end else expTag = "R2";
    for (int ln = 0; ln < 8; ln++) begin
      if (ln < s || mq.size() == 0) it = {1'b1, 8'h07};
      else begin
        it = mq.pop_front();
        if (it == {1'b1, 8'hFD}) mIfg = maxZero(GAP - (8 - ln));
        else expCons++;
      end
      expData[ln*8 +: 8] = it[7:0];
      expCtrl[ln] = it[8];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    int pos, w, endWord;
    bit finished;
    void'($urandom(32'd20240611));
    pos = 0;
    for (int f = 0; f < NF; f++) begin
      fl[f] = (f < 8) ? 8 + f : 8 + int'($urandom % 33);
      fs[f] = pos;
      fb[pos] = 8'h55;
      for (int b = 1; b < fl[f]; b++) fb[pos+b] = 8'($urandom);
      pos += fl[f];
      if (f == 0) rel[f] = 1;
      else if (f < 8) rel[f] = rel[f-1];
      else rel[f] = rel[f-1] + ((($urandom % 5) == 0) ? 9 : 0);
    end

    repeat (3) @(negedge clk);
    checkEq("R8", "reset data", xgmiiData, {8{8'h07}});
    checkEq("R8", "reset ctrl", {56'd0, xgmiiCtrl}, 64'hFF);
    checkEq("R8", "reset strobe", {63'd0, wordValid}, 64'd0);
    checkEq("R9", "reset ready", {63'd0, inReady}, 64'd0);
    rst = 1'b0;

    finished = 0;
    endWord = 0;
    for (int c = 0; c < 140000; c++) begin
      if (c % 8 == 0) begin
        w = c / 8;
        if (w > 0) begin
          checkEq(expTag, $sformatf("word %0d data", w-1), xgmiiData, expData);
          checkEq(expTag, $sformatf("word %0d ctrl", w-1), {56'd0, xgmiiCtrl}, {56'd0, expCtrl});
          checkEq("R8", $sformatf("word %0d strobe", w-1), {63'd0, wordValid}, 64'd1);
          checkEq("R9", $sformatf("word %0d accepted", w-1), 64'(hsCnt), 64'(expCons));
        end
        if (finished && w >= endWord) break;
        {forceLane4, dicEnable} = cfgFor(w);
        modelWord(w);
        hsCnt = 0;
        if (!finished && nextF == NF && mq.size() == 0) begin
          finished = 1;
          endWord = w + 2;
        end
      end
      if (c % 8 == 3) checkEq("R8", "strobe low mid-word", {63'd0, wordValid}, 64'd0);
      if (!active && curF < NF && rel[curF] <= c / 8) begin
        active = 1;
        idx = 0;
      end
      inValid = active;
      inData  = active ? fb[fs[curF]+idx] : 8'h00;
      inLast  = active && (idx == fl[curF] - 1);
      #1;
      if (inValid && inReady) begin
        hsCnt++;
        idx++;
        if (idx == fl[curF]) begin
          active = 0;
          curF++;
        end
      end
      @(negedge clk);
    end
    checkEq("R1", "all frames sent", 64'(curF), 64'(NF));
    report();
    $finish;
  end

endmodule